// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one memory burst, one address per clock. A single-cycle start pulse captures a starting column, a burst-length code and an ordering bit. From the next cycle on, the block presents one column per clock on its output, with a valid strobe. A last-beat flag marks the final address of a fixed-length burst.

Two orderings are available for fixed lengths of 2, 4 or 8 beats. In sequential ordering the address counts up and wraps inside the aligned block whose size is the burst length. In interleaved ordering the low bits of the start column are XORed with the beat number. A full-page setting instead walks the whole column space upward, wrapping at the top, until it is terminated.

A terminate input ends a burst early, as a precharge would. A new start pulse may cut into a running burst at any time and begin again from a fresh column. The column width is a parameter. Its default of 9 bits covers 512 columns.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, valid_o and last_o are 0.
- R2: The cycle after start_i is sampled high, valid_o is 1 and col_o equals the start_col_i value sampled with it (beat 0).
- R3: len_code_i selects the burst length: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats and 3 gives 8 beats. Any code with bit 2 set selects full page. A fixed burst drives valid_o to 0 in the cycle after its final beat.
- R4: With interleave_i = 0 and a fixed length BL = 2^n, beat k has its low n bits equal to (start + k) mod BL. Its higher bits equal those of the start column.
- R5: With interleave_i = 1 and a fixed length BL = 2^n, beat k has its low n bits equal to the start column's low n bits XOR k. Its higher bits equal those of the start column.
- R6: In full page, beat k equals (start + k) mod 2^CW and interleave_i is ignored. The burst continues until it is terminated or restarted, and last_o stays 0.
- R7: last_o is 1 exactly on the final beat of a fixed-length burst and 0 on every other cycle.
- R8: When term_i is sampled high during a burst and start_i is low, valid_o is 0 in the next cycle. When term_i is sampled high with no burst running, it has no effect.
- R9: When start_i is sampled high during a burst, a new burst begins from the new column in the next cycle. This also holds when term_i is high in the same cycle.
- R10: len_code_i and interleave_i are sampled only with start_i. Changing them during a burst does not alter its sequence or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a burst (single-cycle pulse) |
| start_col_i | input | CW | Starting column |
| len_code_i | input | 3 | Burst-length code (see R3) |
| interleave_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| term_i | input | 1 | End the running burst early |
| col_o | output | CW | Current column address |
| valid_o | output | 1 | col_o holds a burst beat |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench builds the block with the default 9-bit column width. With that width, the wrap from column 511 back to 0 in full page is reachable in a few beats. So is an 8-beat block at the very top of the column space, where a sequential carry must not leak into the upper bits. The table drives every fixed length in both orderings from unaligned start columns. Directed runs cover early termination, restart (including restart against a simultaneous terminate), and input changes during a burst.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] start_col_i,
  input  logic [2:0]    len_code_i,
  input  logic          interleave_i,
  input  logic          term_i,
  output logic [CW-1:0] col_o,
  output logic          valid_o,
  output logic          last_o
);

  logic          active;
  logic [CW-1:0] base;
  logic [CW-1:0] beat;
  logic [2:0]    len_q;
  logic          ilv_q;
  logic [CW-1:0] mask;
  logic [CW-1:0] offs;
  logic          page;

  assign page    = len_q[2];
  assign mask    = page ? {CW{1'b1}} : ~({CW{1'b1}} << len_q[1:0]);
  assign offs    = (ilv_q && !page) ? (base ^ beat) : (base + beat);
  assign col_o   = (base & ~mask) | (offs & mask);
  assign valid_o = active;
  assign last_o  = active && !page && (beat == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      beat   <= '0;
      len_q  <= '0;
      ilv_q  <= 1'b0;
    end else if (start_i) begin
      active <= 1'b1;
      base   <= start_col_i;
      beat   <= '0;
      len_q  <= len_code_i;
      ilv_q  <= interleave_i;
    end else if (active) begin
      if (term_i || last_o) active <= 1'b0;
      else                  beat   <= beat + 1'b1;
    end
  end

  // R2 / R9: a start shows its column in the next cycle, whatever term_i does
  p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  // R7: the last flag only rides on a valid beat
  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R3: a fixed burst closes right after its last beat
  p_end_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);

  // R8: terminate closes a burst
  p_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && term_i && !start_i) |=> !valid_o);

  // R6: full page steps by one with wrap and never flags last
  p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && page && !term_i && !start_i) |=>
      (valid_o && !last_o && col_o == $past(col_o) + 1'b1));

  // R4 / R5: bits above the burst block stay fixed during a fixed burst
  p_block_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !page && !last_o && !term_i && !start_i) |=>
      ((col_o & ~mask) == ($past(col_o) & ~mask)));

endmodule

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
  localparam int CW = 9;
  localparam time TCLK = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] start_col_i = '0;
  logic [2:0]    len_code_i = '0;
  logic          interleave_i = 1'b0;
  logic          term_i = 1'b0;
  logic [CW-1:0] col_o;
  logic          valid_o;
  logic          last_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(TCLK/2) clk = ~clk;

  burst_col_gen #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  // len(3) ilv(1) start(9) final(9)
  localparam logic [21:0] VEC [8] = '{
    {3'd0, 1'b0, 9'd5,   9'd5},
    {3'd1, 1'b0, 9'd7,   9'd6},
    {3'd2, 1'b0, 9'd5,   9'd4},
    {3'd2, 1'b1, 9'd5,   9'd6},
    {3'd3, 1'b0, 9'd13,  9'd12},
    {3'd3, 1'b1, 9'd13,  9'd10},
    {3'd1, 1'b1, 9'd511, 9'd510},
    {3'd3, 1'b0, 9'd506, 9'd505}
  };

  function automatic int model(int s, int len, int ilv, int k);
    int n, bl, hi;
    n  = (len >= 4) ? CW : len;
    bl = 1 << n;
    hi = s - (s % bl);
    if (ilv != 0 && len < 4) return hi + ((s % bl) ^ k);
    return hi + ((s + k) % bl);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go(int col, int len, int ilv);
    start_i = 1'b1; start_col_i = CW'(col);
    len_code_i = 3'(len); interleave_i = ilv[0];
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic see(int exp_col, bit exp_last, string tag);
    check(valid_o == 1'b1, {tag, " valid"}, int'(valid_o), 1);
    check(int'(col_o) == exp_col, {tag, " col"}, int'(col_o), exp_col);
    check(last_o == exp_last, {tag, " last"}, int'(last_o), int'(exp_last));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!valid_o && !last_o, "R1 in reset", int'(valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!valid_o && !last_o, "R1 after reset", int'(valid_o), 0);

    // table: R2 R3 R4 R5 R7
    foreach (VEC[i]) begin
      int len, ilv, s, fin, nb;
      len = int'(VEC[i][21:19]); ilv = int'(VEC[i][18]);
      s = int'(VEC[i][17:9]); fin = int'(VEC[i][8:0]);
      nb = 1 << len;
      go(s, len, ilv);
      check(int'(col_o) == s, "R2 first beat", int'(col_o), s);
      for (int k = 0; k < nb; k++) begin
        see(model(s, len, ilv, k), k == nb - 1, ilv ? "R5 ilv beat" : "R4 seq beat");
        if (k == nb - 1) check(int'(col_o) == fin, "R7 final col", int'(col_o), fin);
        @(negedge clk);
      end
      check(!valid_o, "R3 burst ends", int'(valid_o), 0);
    end

    // R6 full page wrap, interleave ignored, then R8 terminate
    go(509, 7, 1);
    for (int k = 0; k < 6; k++) begin
      see((509 + k) % 512, 1'b0, "R6 page beat");
      if (k < 5) @(negedge clk);
    end
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    check(!valid_o, "R8 term page", int'(valid_o), 0);

    // R8 term while idle has no effect
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    check(!valid_o && !last_o, "R8 idle term", int'(valid_o), 0);
    go(20, 1, 0);
    see(20, 1'b0, "R8 after idle term");
    @(negedge clk);
    see(21, 1'b1, "R8 after idle term");
    @(negedge clk);

    // R8 terminate a fixed burst early
    go(0, 3, 0);
    see(0, 1'b0, "R8 mid");
    @(negedge clk);
    see(1, 1'b0, "R8 mid");
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    check(!valid_o && !last_o, "R8 early end", int'(valid_o), 0);

    // R9 restart beats a simultaneous terminate
    go(0, 3, 0);
    see(0, 1'b0, "R9 first");
    @(negedge clk);
    term_i = 1'b1;
    go(41, 2, 0);
    term_i = 1'b0;
    see(41, 1'b0, "R9 restart");
    @(negedge clk);
    see(42, 1'b0, "R9 restart");
    @(negedge clk);
    see(43, 1'b0, "R9 restart");
    @(negedge clk);
    see(40, 1'b1, "R9 restart");
    @(negedge clk);
    check(!valid_o, "R9 end", int'(valid_o), 0);

    // R10 mode inputs change mid burst
    go(8, 2, 0);
    len_code_i = 3'd3; interleave_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      see(8 + k, k == 3, "R10 held mode");
      @(negedge clk);
    end
    check(!valid_o, "R10 length held", int'(valid_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule